// File: doc/BRIEF.md
# Packed BCD Add/Subtract/Negate Unit

This unit does decimal arithmetic on bytes that each hold two packed BCD digits. It has three operations. Add forms source + destination + X. Subtract forms destination − source − X. Negate forms 0 − destination − X. The X input is the extend bit carried over from an earlier byte. The decimal carry or borrow out feeds both the carry and the extend flags. The zero flag is sticky: a nonzero result clears it, and a zero result passes the incoming flag through unchanged. With this behaviour, a long decimal number handled one byte at a time gives a zero flag that is valid for the whole number.

The unit works digit-serially, one decimal digit per clock, starting at the least significant digit. A small sequencer has three states. In ST_IDLE the unit waits for a start request that carries a valid operation code. Taking such a request is the transition IDLE→DIGIT, which loads the operands, the extend bit and the incoming zero flag. ST_DIGIT runs one digit per cycle. It moves DIGIT→DIGIT while digits remain and DIGIT→DONE after the last digit. ST_DONE lasts one cycle, raises `done` and returns DONE→IDLE. The result and the flags stay where they are until the next accepted request.

Operand addressing, whether register or predecrement memory, is the caller's job. The unit only sees two bytes, X and the previous Z. Inputs that are not valid BCD digits give undefined results.

Top module: `bcd_arith_unit`

## Requirements
- R1: After reset, `busy`, `done`, `carry_out` and `z_out` are 0 and `result` is 0x00.
- R2: With op code 0 (add), `result` is the two-digit BCD value of (src + dst + x_in) mod 100, and `carry_out` is 1 exactly when that sum is greater than 99.
- R3: With op code 1 (subtract), `result` is (dst − src − x_in) mod 100 in BCD, and `carry_out` is 1 exactly when the difference is negative.
- R4: With op code 2 (negate), `src` is not used. `result` is (0 − dst − x_in) mod 100 in BCD, and `carry_out` is 1 exactly when the value is negative. With dst = 0x00 and x_in = 0 the result is 0x00 with no borrow.
- R5: `x_in` takes part in the operation of every op code as described in R2–R4, so that carries and borrows pass from one byte to the next.
- R6: When `result` is nonzero, `z_out` is 0.
- R7: When `result` is 0x00, `z_out` equals the `z_in` value sampled when the request was accepted.
- R8: A request is accepted only in ST_IDLE. `done` goes high during the third cycle after the accepting clock edge (that is, DIGITS+1 cycles after start was first presented) and stays high for exactly one cycle. `busy` is high while digits are processed.
- R9: While the unit is busy or done, `start` and changes on the operand inputs have no effect on the result of the operation in progress, and no second operation starts.
- R10: A start with op code 3 (reserved) is ignored. The unit stays idle, `done` stays low and `result`, `carry_out` and `z_out` keep their values.
- R11: Outside the digit-processing cycles, `result`, `carry_out` and `z_out` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation (taken in ST_IDLE) |
| op | input | 2 | 0 add, 1 subtract, 2 negate, 3 reserved |
| src | input | 8 | Source byte, two packed BCD digits |
| dst | input | 8 | Destination byte, two packed BCD digits |
| x_in | input | 1 | Extend bit entering the operation |
| z_in | input | 1 | Zero flag from the previous byte |
| busy | output | 1 | Digits are being processed |
| done | output | 1 | One-cycle pulse: result and flags are valid |
| result | output | 8 | BCD result byte |
| carry_out | output | 1 | Decimal carry or borrow (C and X) |
| z_out | output | 1 | Updated sticky zero flag |

## Verification
The hard cases are the digit corrections that happen only with particular operand pairs. These are a low digit whose binary sum is 10 to 15 with no nibble carry, a low digit that carries past 15 (9+9+1), a borrow that ripples through both digits, and negate of zero with and without the extend bit. The directed tasks pick operand bytes that reach each of these, plus the carry and borrow boundaries at 99 and 00. The reference model works on integers, not nibbles. The sticky zero flag is checked with a chain of bytes. One byte gives a nonzero result and clears Z, and later bytes give zero results and must keep it cleared, or keep it set when Z came in set.

// File: rtl/bcd_arith_pkg.sv
package bcd_arith_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_NEG = 2'd2,
        OP_RSV = 2'd3
    } bcd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DIGIT = 2'd1,
        ST_DONE  = 2'd2
    } bcd_state_e;

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
    import bcd_arith_pkg::*;
(
    input  logic [NIB_W-1:0] a_i,
    input  logic [NIB_W-1:0] b_i,
    input  logic             cin_i,
    input  logic             sub_i,
    output logic [NIB_W-1:0] d_o,
    output logic             cout_o
);

    logic [NIB_W:0] sum_raw;
    logic [NIB_W:0] diff_raw;

    always_comb begin
        sum_raw  = {1'b0, a_i} + {1'b0, b_i} + {{NIB_W{1'b0}}, cin_i};
        diff_raw = {1'b0, a_i} - {1'b0, b_i} - {{NIB_W{1'b0}}, cin_i};
        if (sub_i) begin
            // a borrow leaves a wrapped nibble; take 6 off to return to 0..9
            cout_o = diff_raw[NIB_W];
            if (diff_raw[NIB_W]) begin
                d_o = diff_raw[NIB_W-1:0] - NIB_W'(6);
            end else begin
                d_o = diff_raw[NIB_W-1:0];
            end
        end else begin
            // above nine, or a carry out of the nibble, needs a +6 adjust
            cout_o = (sum_raw > (NIB_W+1)'(9));
            if (cout_o) begin
                d_o = sum_raw[NIB_W-1:0] + NIB_W'(6);
            end else begin
                d_o = sum_raw[NIB_W-1:0];
            end
        end
    end

endmodule

// File: rtl/bcd_seq_ctrl.sv
module bcd_seq_ctrl
    import bcd_arith_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic accept_o,
    output logic step_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;

    bcd_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_digit;

    assign last_digit = (cnt_q == CNT_W'(DIGITS - 1));

    // state register and digit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_DIGIT && state_q == ST_DIGIT) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end else if (state_d == ST_DIGIT) begin
                cnt_q <= '0;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        accept_o = 1'b0;
        step_o   = 1'b0;
        last_o   = 1'b0;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    accept_o = 1'b1;
                    state_d  = ST_DIGIT;
                end
            end
            ST_DIGIT: begin
                busy_o = 1'b1;
                step_o = 1'b1;
                if (last_digit) begin
                    last_o  = 1'b1;
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                done_o  = 1'b1;
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/bcd_arith_unit.sv
module bcd_arith_unit
    import bcd_arith_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               op,
    input  logic [DIGITS*NIB_W-1:0]  src,
    input  logic [DIGITS*NIB_W-1:0]  dst,
    input  logic                     x_in,
    input  logic                     z_in,
    output logic                     busy,
    output logic                     done,
    output logic [DIGITS*NIB_W-1:0]  result,
    output logic                     carry_out,
    output logic                     z_out
);

    localparam int W = DIGITS * NIB_W;

    bcd_op_e        op_e;
    logic           req;
    logic           accept, step, last;
    logic [W-1:0]   opa_q, opb_q, res_q;
    logic           carry_q, sub_q, z_q;
    logic [NIB_W-1:0] dig_d;
    logic           dig_c;
    logic [W-1:0]   res_next;

    assign op_e = bcd_op_e'(op);
    assign req  = start && (op_e != OP_RSV);

    bcd_seq_ctrl #(.DIGITS(DIGITS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req),
        .accept_o (accept),
        .step_o   (step),
        .last_o   (last),
        .busy_o   (busy),
        .done_o   (done)
    );

    bcd_digit_cell u_cell (
        .a_i    (opa_q[NIB_W-1:0]),
        .b_i    (opb_q[NIB_W-1:0]),
        .cin_i  (carry_q),
        .sub_i  (sub_q),
        .d_o    (dig_d),
        .cout_o (dig_c)
    );

    generate
        if (DIGITS > 1) begin : g_multi
            assign res_next = {dig_d, res_q[W-1:NIB_W]};
        end else begin : g_single
            assign res_next = dig_d;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_q   <= '0;
            opb_q   <= '0;
            res_q   <= '0;
            carry_q <= 1'b0;
            sub_q   <= 1'b0;
            z_q     <= 1'b0;
        end else if (accept) begin
            unique case (op_e)
                OP_ADD: begin
                    opa_q <= src;
                    opb_q <= dst;
                    sub_q <= 1'b0;
                end
                OP_SUB: begin
                    opa_q <= dst;
                    opb_q <= src;
                    sub_q <= 1'b1;
                end
                OP_NEG: begin
                    opa_q <= '0;
                    opb_q <= dst;
                    sub_q <= 1'b1;
                end
                default: begin
                    opa_q <= opa_q;
                end
            endcase
            carry_q <= x_in;
            z_q     <= z_in;
        end else if (step) begin
            opa_q   <= opa_q >> NIB_W;
            opb_q   <= opb_q >> NIB_W;
            carry_q <= dig_c;
            if (last) begin
                res_q <= res_next;
                if (res_next != '0) begin
                    z_q <= 1'b0;
                end
            end else begin
                res_q <= res_next;
            end
        end
    end

    // flags are published only on the last digit
    logic carry_pub_q, z_pub_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_pub_q <= 1'b0;
            z_pub_q     <= 1'b0;
        end else if (step && last) begin
            carry_pub_q <= dig_c;
            z_pub_q     <= (res_next != '0) ? 1'b0 : z_q;
        end
    end

    // result register is exposed only once complete
    logic [W-1:0] res_pub_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_pub_q <= '0;
        end else if (step && last) begin
            res_pub_q <= res_next;
        end
    end

    assign result    = res_pub_q;
    assign carry_out = carry_pub_q;
    assign z_out     = z_pub_q;

endmodule

// File: rtl/bcd_arith_chk.sv
module bcd_arith_chk
    import bcd_arith_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [1:0]              op,
    input logic                    busy,
    input logic                    done,
    input logic [DIGITS*NIB_W-1:0] result,
    input logic                    carry_out,
    input logic                    z_out
);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R10
    reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start && op == 2'd3) |=> (!busy && !done));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(result) && $stable(carry_out) && $stable(z_out)));

    // R6
    z_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != '0) |-> !z_out);

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

bind bcd_arith_unit bcd_arith_chk #(.DIGITS(DIGITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .carry_out (carry_out),
    .z_out     (z_out)
);

// File: tb/tb_bcd_arith_unit.sv
module tb_bcd_arith_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op = 2'd0;
    logic [7:0] src = 8'h00;
    logic [7:0] dst = 8'h00;
    logic       x_in = 1'b0;
    logic       z_in = 1'b0;
    logic       busy, done, carry_out, z_out;
    logic [7:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bcd_arith_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src(src), .dst(dst),
        .x_in(x_in), .z_in(z_in), .busy(busy), .done(done), .result(result),
        .carry_out(carry_out), .z_out(z_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int to_int(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        logic [7:0] r;
        r[7:4] = 4'((v / 10) % 10);
        r[3:0] = 4'(v % 10);
        return r;
    endfunction

    // one operation, latency and result checks
    task automatic run_op(input string req, input logic [1:0] o, input logic [7:0] s,
                          input logic [7:0] d, input logic x, input logic z);
        int v, k;
        logic [7:0] er;
        logic ec, ez;
        case (o)
            2'd0:    v = to_int(s) + to_int(d) + int'(x);
            2'd1:    v = to_int(d) - to_int(s) - int'(x);
            default: v = 0 - to_int(d) - int'(x);
        endcase
        ec = (v > 99) || (v < 0);
        er = to_bcd((v + 100) % 100);
        ez = (er != 8'h00) ? 1'b0 : z;
        @(negedge clk);
        op = o; src = s; dst = d; x_in = x; z_in = z; start = 1'b1;
        k = 0;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 10) begin
            @(negedge clk);
            k++;
        end
        chk({req, " latency"}, k, 3);
        chk({req, " result"}, int'(result), int'(er));
        chk({req, " carry"}, int'(carry_out), int'(ec));
        chk({req, " zflag"}, int'(z_out), int'(ez));
        @(negedge clk);
        chk("R8 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 result", int'(result), 0);
        chk("R1 carry", int'(carry_out), 0);
        chk("R1 z", int'(z_out), 0);
    endtask

    task automatic t_add();
        run_op("R2 add basic", 2'd0, 8'h12, 8'h34, 1'b0, 1'b1);
        run_op("R2 add digit adjust", 2'd0, 8'h05, 8'h07, 1'b0, 1'b1);
        run_op("R2 add 9+9+x", 2'd0, 8'h09, 8'h09, 1'b1, 1'b0);
        run_op("R2 add overflow 99", 2'd0, 8'h99, 8'h01, 1'b0, 1'b1);
        run_op("R2 add 99+99+x", 2'd0, 8'h99, 8'h99, 1'b1, 1'b0);
        run_op("R5 add with x", 2'd0, 8'h45, 8'h54, 1'b1, 1'b0);
    endtask

    task automatic t_sub();
        run_op("R3 sub basic", 2'd1, 8'h12, 8'h57, 1'b0, 1'b0);
        run_op("R3 sub low borrow", 2'd1, 8'h08, 8'h23, 1'b0, 1'b0);
        run_op("R3 sub full borrow", 2'd1, 8'h01, 8'h00, 1'b0, 1'b0);
        run_op("R5 sub with x", 2'd1, 8'h50, 8'h50, 1'b1, 1'b0);
        run_op("R3 sub equal", 2'd1, 8'h37, 8'h37, 1'b0, 1'b1);
    endtask

    task automatic t_neg();
        run_op("R4 neg zero", 2'd2, 8'hFF, 8'h00, 1'b0, 1'b1);
        run_op("R4 neg zero with x", 2'd2, 8'h00, 8'h00, 1'b1, 1'b1);
        run_op("R4 neg value", 2'd2, 8'h77, 8'h25, 1'b0, 1'b0);
        run_op("R5 neg with x", 2'd2, 8'h00, 8'h10, 1'b1, 1'b0);
    endtask

    task automatic t_sticky_z();
        run_op("R6 chain nonzero", 2'd0, 8'h00, 8'h03, 1'b0, 1'b1);
        run_op("R7 chain zero keeps clear", 2'd0, 8'h00, 8'h00, 1'b0, z_out);
        run_op("R7 chain zero keeps set", 2'd1, 8'h00, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic t_busy_ignore();
        int k;
        @(negedge clk);
        op = 2'd0; src = 8'h21; dst = 8'h43; x_in = 1'b0; z_in = 1'b0; start = 1'b1;
        @(negedge clk);
        k = 1;
        op = 2'd1; src = 8'h99; dst = 8'h11; x_in = 1'b1;
        while (!done && k < 10) begin
            @(negedge clk);
            k++;
        end
        start = 1'b1;
        chk("R9 result unaffected", int'(result), 'h64);
        chk("R9 carry unaffected", int'(carry_out), 0);
        @(negedge clk);
        start = 1'b0;
        chk("R9 no restart from done", int'(busy), 0);
        chk("R9 held after", int'(result), 'h64);
    endtask

    task automatic t_reserved();
        logic [7:0] r0;
        logic c0, z0;
        r0 = result; c0 = carry_out; z0 = z_out;
        @(negedge clk);
        op = 2'd3; src = 8'h11; dst = 8'h22; x_in = 1'b1; z_in = ~z0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 stays idle", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk("R10 no done", int'(done), 0);
        chk("R10 result kept", int'(result), int'(r0));
        chk("R10 flags kept", int'({carry_out, z_out}), int'({c0, z0}));
    endtask

    task automatic t_hold();
        logic [7:0] r0;
        r0 = result;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            src = 8'(i * 17); dst = 8'(i * 3); x_in = ~x_in; z_in = ~z_in;
        end
        @(negedge clk);
        chk("R11 result held", int'(result), int'(r0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_add();
        t_sub();
        t_neg();
        t_sticky_z();
        t_busy_ignore();
        t_reserved();
        t_hold();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule